// File: doc/BRIEF.md
# Single-Channel DMA Address Sequencer

This block is one channel of a short-address DMA engine. A configuration strobe loads the channel settings in one cycle. These settings are a transfer size bit, an address direction bit, a repeat bit, an interrupt enable bit, a memory-to-I/O select bit, the channel enable, a 24-bit memory address, a 16-bit transfer count and an 8-bit I/O address. The I/O address sits on a fixed page at the top of the address space. Each accepted transfer request runs one byte or word move on a simple bus master port. The move has a read phase at the source followed by a write phase at the destination. After the write completes, the channel steps its memory address and its counter according to the operating mode.

The operating mode comes from the repeat bit and the interrupt enable bit taken together. In I/O mode the address moves on every transfer and the channel stops when the 16-bit count runs out. In repeat mode the low count byte acts as a block counter. At the end of each block the counter reloads from the high byte and the address returns to its starting point, so the channel never stops by itself. In idle mode the address stays fixed while the count runs down, which suits a single peripheral register. Whenever the enable bit falls, the channel can pulse an end interrupt.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, chan_en, busy, bus_req and end_irq are 0, and the configuration holds byte size and interrupt enable 0.
- R2: A transfer first reads the source and then writes the destination, with bus_we 0 and then 1. The address is held until bus_ack. With cfg_mem2io=1 the source is the memory address and the destination is the I/O address {16'hFFFF, io}. With cfg_mem2io=0 the two are swapped. The write data equals the read data; a byte transfer passes bus_rdata[7:0] with the upper byte forced to 0.
- R3: bus_word equals the size bit (0 = byte, 1 = word). Outside idle mode the memory address moves by 1 for byte and 2 for word transfers.
- R4: With the direction bit at 0 the memory address goes up after a transfer; with it at 1 the address goes down. The address wraps modulo 2^24.
- R5: The mode is decoded from the repeat and interrupt enable bits: repeat 0 gives I/O mode whatever the interrupt enable holds, repeat 1 with enable 0 gives repeat mode, and both at 1 give idle mode.
- R6: In idle mode the memory address does not change after a transfer, while the 16-bit count still decrements.
- R7: In I/O and idle modes the 16-bit count decrements once per transfer. The transfer that brings it to 0 also clears chan_en.
- R8: In repeat mode only the low count byte decrements. When it would reach 0, it reloads from the high byte, the memory address returns to the last configured value, and chan_en stays 1.
- R9: end_irq is a one-cycle pulse in the first cycle chan_en reads 0 after being 1, and only if interrupt enable is 1. This applies both to the end of a count and to a configuration write that clears the enable.
- R10: A request while chan_en is 0 is ignored: no bus cycle starts.
- R11: A request during a transfer, including the cycle of the final write acknowledge, is held and starts the next transfer right after completion. It is dropped if that completion clears chan_en.
- R12: busy is 1 from the first read cycle until the write is acknowledged. A configuration write while busy is ignored. One written while not busy takes effect, and in that cycle no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_word | input | 1 | Size: 0 byte, 1 word |
| cfg_dec | input | 1 | Direction: 0 up, 1 down |
| cfg_rpt | input | 1 | Repeat bit |
| cfg_irq_en | input | 1 | End interrupt enable |
| cfg_mem2io | input | 1 | 1: memory to I/O, 0: I/O to memory |
| cfg_en | input | 1 | Channel enable value |
| cfg_mar | input | 24 | Memory start address |
| cfg_cnt | input | 16 | Transfer count (repeat: high byte reload, low byte counter) |
| cfg_io | input | 8 | I/O address low byte |
| req | input | 1 | Transfer request |
| bus_ack | input | 1 | Bus phase complete |
| bus_rdata | input | 16 | Read data |
| bus_req | output | 1 | Bus phase active |
| bus_we | output | 1 | 1 in the write phase |
| bus_word | output | 1 | Word-size access |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data |
| busy | output | 1 | Transfer in progress |
| chan_en | output | 1 | Channel enable bit |
| mar_out | output | 24 | Current memory address |
| cnt_out | output | 16 | Current count |
| end_irq | output | 1 | End-of-transfer interrupt pulse |

## Verification
The sharpest collision is a new request arriving in the same cycle as the final write acknowledge. The held request then has to be kept and serviced when the channel stays enabled, and dropped when that completion ends the channel. The bench raises req exactly on the acknowledge cycle in both situations. It then watches bus_req in the following cycles: a read phase must start at once without a fresh request in the first case and must never start in the second. A configuration write is also dropped into the middle of a read phase and judged by the address and enable seen afterwards.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    parameter int ADDR_W = 24;
    parameter int CNT_W  = 16;
    parameter int DATA_W = 16;
    parameter int IO_W   = 8;

    typedef enum logic [1:0] {
        MODE_IO   = 2'd0,
        MODE_RPT  = 2'd1,
        MODE_IDLE = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2
    } phase_e;

    typedef struct packed {
        logic word;
        logic dec;
        logic rpt;
        logic irq_en;
        logic mem2io;
    } ctl_t;

    function automatic mode_e mode_of(input logic rpt, input logic irq_en);
        if (!rpt)
            return MODE_IO;
        else if (!irq_en)
            return MODE_RPT;
        else
            return MODE_IDLE;
    endfunction

endpackage

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_seq_pkg::*;
#(
    parameter int IOW = IO_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  ctl_t           cfg_ctl,
    input  logic           cfg_en,
    input  logic [IOW-1:0] cfg_io,
    input  logic           busy,
    input  logic           last,
    output ctl_t           ctl,
    output logic           en,
    output logic [IOW-1:0] io,
    output logic           end_irq
);

    logic wr_ok;
    assign wr_ok = cfg_we && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            en      <= 1'b0;
            io      <= '0;
            end_irq <= 1'b0;
        end else begin
            end_irq <= 1'b0;
            if (wr_ok) begin
                ctl     <= cfg_ctl;
                en      <= cfg_en;
                io      <= cfg_io;
                end_irq <= en && !cfg_en && cfg_ctl.irq_en;
            end else if (last) begin
                en      <= 1'b0;
                end_irq <= ctl.irq_en;
            end
        end
    end

    // R9
    end_irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        end_irq |-> (!en && $past(en) && ctl.irq_en));

    // R12
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(ctl) && $stable(io)));

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_seq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] cfg_mar,
    input  logic [CW-1:0] cfg_cnt,
    input  mode_e         mode,
    input  logic          word,
    input  logic          dec,
    input  logic          step,
    output logic [AW-1:0] mar,
    output logic [CW-1:0] cnt,
    output logic          last
);

    localparam int RW = CW / 2;

    logic [AW-1:0] start_q;
    logic [AW-1:0] delta;
    logic [AW-1:0] mar_step;
    logic          rpt_wrap;

    assign delta    = word ? AW'(2) : AW'(1);
    assign mar_step = dec ? (mar - delta) : (mar + delta);
    assign rpt_wrap = (cnt[RW-1:0] == RW'(1));
    assign last     = step && (mode != MODE_RPT) && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mar     <= '0;
            start_q <= '0;
            cnt     <= '0;
        end else if (load) begin
            mar     <= cfg_mar;
            start_q <= cfg_mar;
            cnt     <= cfg_cnt;
        end else if (step) begin
            case (mode)
                MODE_IDLE: begin
                    cnt <= cnt - CW'(1);
                end
                MODE_RPT: begin
                    if (rpt_wrap) begin
                        cnt[RW-1:0] <= cnt[CW-1:RW];
                        mar         <= start_q;
                    end else begin
                        cnt[RW-1:0] <= cnt[RW-1:0] - RW'(1);
                        mar         <= mar_step;
                    end
                end
                default: begin
                    cnt <= cnt - CW'(1);
                    mar <= mar_step;
                end
            endcase
        end
    end

    // R6
    idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (step && mode == MODE_IDLE) |=> ($stable(mar) && cnt == $past(cnt) - CW'(1)));

    // R8
    rpt_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (step && mode == MODE_RPT) |=> $stable(cnt[CW-1:RW]));

    // R7
    last_zero_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> (cnt == '0));

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_seq_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int IOW = IO_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           req,
    input  logic           cfg_we,
    input  logic           word,
    input  logic           mem2io,
    input  logic [AW-1:0]  mar,
    input  logic [IOW-1:0] io,
    input  logic           last,
    input  logic           bus_ack,
    input  logic [DW-1:0]  bus_rdata,
    output logic           bus_req,
    output logic           bus_we,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    output logic           busy,
    output logic           step
);

    localparam int BW = DW / 2;

    phase_e        phase;
    logic          pend;
    logic [DW-1:0] data_q;
    logic          start;
    logic [AW-1:0] io_full;

    assign io_full   = {{(AW-IOW){1'b1}}, io};
    assign start     = (phase == PH_IDLE) && en && (req || pend) && !cfg_we;
    assign busy      = (phase != PH_IDLE);
    assign step      = (phase == PH_WR) && bus_ack;
    assign bus_req   = busy;
    assign bus_we    = (phase == PH_WR);
    assign bus_wdata = data_q;

    always_comb begin
        if ((phase == PH_RD) == mem2io)
            bus_addr = mar;
        else
            bus_addr = io_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            pend   <= 1'b0;
            data_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) phase <= PH_RD;
                PH_RD: if (bus_ack) begin
                    data_q <= word ? bus_rdata : {{(DW-BW){1'b0}}, bus_rdata[BW-1:0]};
                    phase  <= PH_WR;
                end
                PH_WR: if (bus_ack) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
            if (phase == PH_IDLE || last)
                pend <= 1'b0;
            else if (req)
                pend <= 1'b1;
        end
    end

    // R12
    busy_en_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> en);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R10
    no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !busy) |=> !bus_req);

    // R2
    phase_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> !bus_we);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int CW  = CNT_W,
    parameter int DW  = DATA_W,
    parameter int IOW = IO_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic           cfg_word,
    input  logic           cfg_dec,
    input  logic           cfg_rpt,
    input  logic           cfg_irq_en,
    input  logic           cfg_mem2io,
    input  logic           cfg_en,
    input  logic [AW-1:0]  cfg_mar,
    input  logic [CW-1:0]  cfg_cnt,
    input  logic [IOW-1:0] cfg_io,
    input  logic           req,
    input  logic           bus_ack,
    input  logic [DW-1:0]  bus_rdata,
    output logic           bus_req,
    output logic           bus_we,
    output logic           bus_word,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    output logic           busy,
    output logic           chan_en,
    output logic [AW-1:0]  mar_out,
    output logic [CW-1:0]  cnt_out,
    output logic           end_irq
);

    ctl_t           cfg_ctl;
    ctl_t           ctl;
    mode_e          mode;
    logic [IOW-1:0] io;
    logic           last;
    logic           step;

    assign cfg_ctl  = '{word: cfg_word, dec: cfg_dec, rpt: cfg_rpt,
                        irq_en: cfg_irq_en, mem2io: cfg_mem2io};
    assign mode     = mode_of(ctl.rpt, ctl.irq_en);
    assign bus_word = ctl.word;

    dma_ctl_regs #(.IOW(IOW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (cfg_we),
        .cfg_ctl (cfg_ctl),
        .cfg_en  (cfg_en),
        .cfg_io  (cfg_io),
        .busy    (busy),
        .last    (last),
        .ctl     (ctl),
        .en      (chan_en),
        .io      (io),
        .end_irq (end_irq)
    );

    dma_addr_unit #(.AW(AW), .CW(CW)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_we && !busy),
        .cfg_mar (cfg_mar),
        .cfg_cnt (cfg_cnt),
        .mode    (mode),
        .word    (ctl.word),
        .dec     (ctl.dec),
        .step    (step),
        .mar     (mar_out),
        .cnt     (cnt_out),
        .last    (last)
    );

    dma_xfer_fsm #(.AW(AW), .DW(DW), .IOW(IOW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (chan_en),
        .req       (req),
        .cfg_we    (cfg_we),
        .word      (ctl.word),
        .mem2io    (ctl.mem2io),
        .mar       (mar_out),
        .io        (io),
        .last      (last),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .step      (step)
    );

    // R5
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_IO) |-> ctl.rpt);

    // R8
    rpt_keeps_en_chk: assert property (@(posedge clk) disable iff (rst)
        (step && mode == MODE_RPT) |=> chan_en);

endmodule

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 0, cfg_word = 0, cfg_dec = 0, cfg_rpt = 0;
    logic        cfg_irq_en = 0, cfg_mem2io = 0, cfg_en = 0;
    logic [23:0] cfg_mar = '0;
    logic [15:0] cfg_cnt = '0;
    logic [7:0]  cfg_io = '0;
    logic        req = 0, bus_ack = 0;
    logic [15:0] bus_rdata = '0;
    logic        bus_req, bus_we, bus_word, busy, chan_en, end_irq;
    logic [23:0] bus_addr, mar_out;
    logic [15:0] bus_wdata, cnt_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [23:0] m_mar, m_start;
    logic [15:0] m_cnt;
    logic [7:0]  m_io;
    logic        m_en, m_word, m_dec, m_rpt, m_irq, m_m2i, m_pulse;

    always #5 clk = ~clk;

    dma_chan_seq u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_word(cfg_word), .cfg_dec(cfg_dec),
        .cfg_rpt(cfg_rpt), .cfg_irq_en(cfg_irq_en), .cfg_mem2io(cfg_mem2io),
        .cfg_en(cfg_en), .cfg_mar(cfg_mar), .cfg_cnt(cfg_cnt), .cfg_io(cfg_io),
        .req(req), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy(busy), .chan_en(chan_en), .mar_out(mar_out),
        .cnt_out(cnt_out), .end_irq(end_irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] f_step(input logic [23:0] a, input logic w, input logic d);
        logic [23:0] s;
        s = w ? 24'd2 : 24'd1;
        return d ? a - s : a + s;
    endfunction

    // 0 = I/O, 1 = repeat, 2 = idle (R5)
    function automatic int f_mode(input logic r, input logic ie);
        if (!r) return 0;
        return ie ? 2 : 1;
    endfunction

    task automatic model_step();
        int md;
        md = f_mode(m_rpt, m_irq);
        m_pulse = 0;
        if (md == 1) begin
            if (m_cnt[7:0] == 8'd1) begin
                m_cnt[7:0] = m_cnt[15:8];
                m_mar = m_start;
            end else begin
                m_cnt[7:0] = m_cnt[7:0] - 8'd1;
                m_mar = f_step(m_mar, m_word, m_dec);
            end
        end else begin
            if (md == 0) m_mar = f_step(m_mar, m_word, m_dec);
            m_cnt = m_cnt - 16'd1;
            if (m_cnt == 16'd0) begin
                m_en = 0;
                m_pulse = m_irq;
            end
        end
    endtask

    task automatic cfg(input logic w, input logic d, input logic r, input logic ie,
                       input logic m2i, input logic en, input logic [23:0] a,
                       input logic [15:0] c, input logic [7:0] io);
        @(negedge clk);
        cfg_we = 1; cfg_word = w; cfg_dec = d; cfg_rpt = r; cfg_irq_en = ie;
        cfg_mem2io = m2i; cfg_en = en; cfg_mar = a; cfg_cnt = c; cfg_io = io;
        @(negedge clk);
        cfg_we = 0;
        m_pulse = m_en && !en && ie;
        m_word = w; m_dec = d; m_rpt = r; m_irq = ie; m_m2i = m2i; m_en = en;
        m_mar = a; m_start = a; m_cnt = c; m_io = io;
        check(end_irq == m_pulse, "R9 cfg end_irq", end_irq, m_pulse);
        check(chan_en == m_en && mar_out == m_mar && cnt_out == m_cnt,
              "R12 cfg load", {chan_en, mar_out}, {m_en, m_mar});
    endtask

    task automatic xfer(input logic [15:0] rd, input int d1, input int d2,
                        input bit use_req, input bit req_end, input bit poke);
        logic [23:0] src, dst, iof;
        logic [15:0] wexp;
        int md;
        iof = {16'hFFFF, m_io};
        src = m_m2i ? m_mar : iof;
        dst = m_m2i ? iof : m_mar;
        wexp = m_word ? rd : {8'h00, rd[7:0]};
        md = f_mode(m_rpt, m_irq);
        @(negedge clk);
        req = use_req;
        @(negedge clk);
        req = 0;
        check(bus_req && !bus_we, "R2 read phase", {bus_req, bus_we}, 2'b10);
        check(bus_addr == src, "R2 source addr", bus_addr, src);
        check(bus_word == m_word, "R3 size", bus_word, m_word);
        for (int i = 0; i < d1; i++) begin
            if (poke && i == 0) begin
                cfg_we = 1; cfg_en = 0; cfg_mar = 24'h555555; cfg_cnt = 16'h0009;
            end
            @(negedge clk);
            cfg_we = 0;
            check(busy && bus_req && !bus_we, "R12 busy in read", busy, 1);
        end
        bus_ack = 1; bus_rdata = rd;
        @(negedge clk);
        bus_ack = 0; bus_rdata = 16'hDEAD;
        check(bus_req && bus_we, "R2 write phase", {bus_req, bus_we}, 2'b11);
        check(bus_addr == dst, "R2 dest addr", bus_addr, dst);
        check(bus_wdata == wexp, "R2 data", bus_wdata, wexp);
        for (int i = 0; i < d2; i++) @(negedge clk);
        bus_ack = 1; req = req_end;
        @(negedge clk);
        bus_ack = 0; req = 0;
        model_step();
        check(!busy, "R12 busy drop", busy, 0);
        if (md == 1)
            check(mar_out == m_mar && cnt_out == m_cnt, "R8 repeat update", mar_out, m_mar);
        else if (md == 2)
            check(mar_out == m_mar && cnt_out == m_cnt, "R6 idle update", mar_out, m_mar);
        else
            check(mar_out == m_mar && cnt_out == m_cnt, "R4 io update", mar_out, m_mar);
        check(chan_en == m_en, "R7 enable", chan_en, m_en);
        check(end_irq == m_pulse, "R9 end pulse", end_irq, m_pulse);
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!bus_req && !busy, tag, bus_req, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        m_en = 0; m_irq = 0; m_pulse = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check(!chan_en && !busy && !bus_req && !end_irq, "R1 reset outputs",
              {chan_en, busy, bus_req, end_irq}, 0);
        check(!bus_word, "R1 reset size", bus_word, 0);

        // R10: request while disabled
        @(negedge clk); req = 1; @(negedge clk); req = 0;
        quiet(3, "R10 ignored request");

        // I/O mode, memory to I/O, word, up; held request at last ack dropped (R11)
        cfg(1, 0, 0, 0, 1, 1, 24'h000100, 16'd2, 8'h40);
        xfer(16'hA5C3, 1, 0, 1, 0, 0);
        xfer(16'h1234, 0, 2, 1, 1, 0);
        quiet(3, "R11 request dropped at end");
        check(!chan_en, "R7 count end", chan_en, 0);

        // I/O mode with irq enabled, byte, down, wrap below zero (R4, R9, R5)
        cfg(0, 1, 0, 1, 0, 1, 24'h000000, 16'd1, 8'h07);
        xfer(16'hBEEF, 0, 0, 1, 0, 0);
        check(mar_out == 24'hFFFFFF, "R4 wrap down", mar_out, 24'hFFFFFF);

        // wrap upward with word step (R3, R4)
        cfg(1, 0, 0, 0, 1, 1, 24'hFFFFFF, 16'd3, 8'h11);
        xfer(16'h0F0F, 0, 1, 1, 0, 0);
        check(mar_out == 24'h000001, "R4 wrap up", mar_out, 24'h000001);

        // repeat mode; pending request at non-final ack (R8, R11)
        cfg(1, 0, 1, 0, 1, 1, 24'h000010, 16'h0202, 8'h22);
        xfer(16'h1111, 0, 0, 1, 1, 0);
        xfer(16'h2222, 1, 1, 0, 0, 0);
        check(mar_out == 24'h000010 && cnt_out == 16'h0202, "R8 reload", mar_out, 24'h10);
        xfer(16'h3333, 0, 0, 1, 0, 0);
        check(chan_en, "R8 enable kept", chan_en, 1);

        // idle mode: address frozen, ends with interrupt (R6, R9)
        cfg(0, 0, 1, 1, 0, 1, 24'h00ABCD, 16'd2, 8'h33);
        xfer(16'h4444, 0, 0, 1, 0, 0);
        check(mar_out == 24'h00ABCD, "R6 frozen", mar_out, 24'h00ABCD);
        xfer(16'h5555, 1, 0, 1, 0, 0);

        // configuration write while busy is ignored (R12)
        cfg(1, 0, 0, 0, 1, 1, 24'h000200, 16'd5, 8'h44);
        xfer(16'h6666, 2, 0, 1, 0, 1);
        check(chan_en && mar_out == 24'h000202, "R12 write ignored", mar_out, 24'h202);

        // disabling write with irq on and off (R9)
        cfg(0, 0, 0, 1, 1, 0, 24'h0, 16'd1, 8'h0);
        cfg(0, 0, 0, 0, 1, 1, 24'h0, 16'd1, 8'h0);
        cfg(0, 0, 0, 0, 1, 0, 24'h0, 16'd1, 8'h0);

        // random transfers across modes (R5)
        for (int it = 0; it < 60; it++) begin
            if (!m_en) begin
                logic r;
                logic [15:0] c;
                r = 1'($urandom_range(0, 1));
                c = r ? {8'($urandom_range(1, 3)), 8'($urandom_range(1, 3))}
                      : 16'($urandom_range(1, 4));
                cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), r,
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1,
                    24'($urandom), c, 8'($urandom));
            end
            xfer(16'($urandom), $urandom_range(0, 2), $urandom_range(0, 2), 1, 0, 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule